// File: doc/BRIEF.md
# Black Loop Gain Boost Timer

This block decides whether the black-level correction loop of an image-sensor front end runs at high or at low gain. A serial-interface access starts a boost window. The window lasts a programmed number of optical-black pulses, and the loop runs at high gain for that time. When the last counted pulse ends, the gain falls back to low and stays there until the next access. A separate force bit holds the gain high for as long as it is set.

All inputs are sampled on the block clock. The end of an access is the moment the active-low serial select line returns high. One optical-black pulse is counted each time the pulse line falls from high to low. The boost period is taken from `period` at the moment the access ends. Power-down and reset both clear the window and pull the flag low.

Top module: `boost_gain_timer`

## Requirements
- R1: While reset is asserted and after its release, `high_gain` is 0 until an access or the force bit raises it.
- R2: An access end is a low-to-high transition of `sel_n` seen between two consecutive clock samples. If `period` is nonzero at that moment and power-down is low, `high_gain` is 1 on the next clock.
- R3: After an access that loaded period N (1..7), `high_gain` stays 1 through the first N-1 falling edges of `ob_pulse` and goes to 0 on the clock that samples the Nth falling edge.
- R4: An access with `period` equal to 0 leaves `high_gain` at 0 when the force bit is low.
- R5: When `force_high` is 1 and `pwr_down` is 0, `high_gain` is 1 on the next clock, whatever the period or count.
- R6: An access during an active window reloads the full period, so N further falling edges are needed before the gain drops.
- R7: While no window is active, falling edges of `ob_pulse` leave `high_gain` at 0.
- R8: `pwr_down` at 1 drives `high_gain` to 0 on the next clock, even when `force_high` is 1. It clears the window, and access ends seen during power-down are discarded.
- R9: The period is captured at the access end. A later change of `period` does not alter the running window.
- R10: When an access end and a falling edge of `ob_pulse` are sampled on the same clock, the reload wins and the falling edge is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_down | input | 1 | Power-down request; clears the window and holds the flag low |
| sel_n | input | 1 | Serial select, active low; its rising edge marks an access end |
| ob_pulse | input | 1 | Optical-black pulse; each falling edge counts one period |
| period | input | PERIOD_W | Boost length in optical-black pulses, 0 = no boost |
| force_high | input | 1 | Holds the loop at high gain while set |
| high_gain | output | 1 | 1 = black loop at high gain |

## Verification
The bench sweeps every period with the force bit both clear and set. After each optical-black pulse it checks the flag against a count computed in the bench. An off-by-one counter would drop the gain one pulse early or late, and a design that ignored period 0 would boost when it should not. Further cases cover a retrigger in the middle of a window, a period change during a window, and an access end that coincides with a pulse edge. A design that decremented on that coincident edge would end the window one pulse early. Power-down is applied with force set and with access ends arriving during it. A design that let either through would show high gain where low is required.

// File: rtl/bgt_pkg.sv
package bgt_pkg;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_kind_e;

endpackage

// File: rtl/bgt_edge_detect.sv
module bgt_edge_detect #(
    parameter bgt_pkg::edge_kind_e KIND       = bgt_pkg::EDGE_RISE,
    parameter logic                IDLE_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic evt_o
);
    typedef struct packed {
        logic prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sig_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.prev <= IDLE_LEVEL;
        else        st_q      <= st_d;
    end

    generate
        if (KIND == bgt_pkg::EDGE_RISE) begin : g_rise
            assign evt_o = sig_i & ~st_q.prev;
        end else begin : g_fall
            assign evt_o = ~sig_i & st_q.prev;
        end
    endgenerate
endmodule

// File: rtl/bgt_window_counter.sv
module bgt_window_counter #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         step_i,
    output logic         active_next_o
);
    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] ONE  = W'(1);

    typedef struct packed {
        logic [W-1:0] remain;
    } win_state_t;

    win_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.remain = ZERO;
        end else if (load_i) begin
            st_d.remain = load_val_i;
        end else if (step_i && st_q.remain != ZERO) begin
            st_d.remain = st_q.remain - ONE;
        end
    end

    assign active_next_o = (st_d.remain != ZERO);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.remain <= ZERO;
        else        st_q        <= st_d;
    end
endmodule

// File: rtl/boost_gain_timer.sv
module boost_gain_timer #(
    parameter int PERIOD_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pwr_down,
    input  logic                sel_n,
    input  logic                ob_pulse,
    input  logic [PERIOD_W-1:0] period,
    input  logic                force_high,
    output logic                high_gain
);
    typedef struct packed {
        logic hg;
    } top_state_t;

    top_state_t st_d, st_q;
    logic access_evt;
    logic ob_fall_evt;
    logic win_active_next;

    bgt_edge_detect #(
        .KIND      (bgt_pkg::EDGE_RISE),
        .IDLE_LEVEL(1'b1)
    ) u_sel_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sig_i(sel_n),
        .evt_o(access_evt)
    );

    bgt_edge_detect #(
        .KIND      (bgt_pkg::EDGE_FALL),
        .IDLE_LEVEL(1'b0)
    ) u_ob_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sig_i(ob_pulse),
        .evt_o(ob_fall_evt)
    );

    bgt_window_counter #(
        .W(PERIOD_W)
    ) u_window (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (pwr_down),
        .load_i       (access_evt),
        .load_val_i   (period),
        .step_i       (ob_fall_evt),
        .active_next_o(win_active_next)
    );

    always_comb begin
        st_d    = st_q;
        st_d.hg = ~pwr_down & (force_high | win_active_next);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.hg <= 1'b0;
        else        st_q    <= st_d;
    end

    assign high_gain = st_q.hg;
endmodule

// File: rtl/bgt_checker.sv
module bgt_checker #(
    parameter int PERIOD_W = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                pwr_down,
    input logic                sel_n,
    input logic                ob_pulse,
    input logic [PERIOD_W-1:0] period,
    input logic                force_high,
    input logic                high_gain
);
    p_reset_low_r1: assert property (@(posedge clk)
        !rst_n |-> !high_gain);

    p_load_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(sel_n) && period != '0 && !pwr_down) |=> high_gain);

    p_zero_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !high_gain && $rose(sel_n) && period == '0 && !force_high)
        |=> !high_gain);

    p_force_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (force_high && !pwr_down) |=> high_gain);

    p_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!high_gain && !$rose(sel_n) && !force_high) |=> !high_gain);

    p_pd_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> !high_gain);
endmodule

bind boost_gain_timer bgt_checker #(.PERIOD_W(PERIOD_W)) u_bgt_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_down  (pwr_down),
    .sel_n     (sel_n),
    .ob_pulse  (ob_pulse),
    .period    (period),
    .force_high(force_high),
    .high_gain (high_gain)
);

// File: tb/boost_gain_timer_test.sv
module boost_gain_timer_test;
    localparam int PW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwr_down = 1'b0;
    logic          sel_n = 1'b1;
    logic          ob_pulse = 1'b0;
    logic [PW-1:0] period = '0;
    logic          force_high = 1'b0;
    logic          high_gain;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    boost_gain_timer #(.PERIOD_W(PW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_down  (pwr_down),
        .sel_n     (sel_n),
        .ob_pulse  (ob_pulse),
        .period    (period),
        .force_high(force_high),
        .high_gain (high_gain)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic exp);
        checks++;
        if (high_gain !== exp) begin
            errors++;
            $display("FAIL %s: high_gain=%b expected %b at %0t", req, high_gain, exp, $time);
        end
    endtask

    task automatic access();
        sel_n = 1'b0;
        tick();
        sel_n = 1'b1;
        tick();
    endtask

    task automatic ob_one();
        ob_pulse = 1'b1;
        tick();
        ob_pulse = 1'b0;
        tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick();
        check("R1 in reset", 1'b0);
        tick();
        rst_n = 1'b1;
        tick();
        tick();
        check("R1 after reset", 1'b0);

        // R7: pulses with no window
        for (int k = 0; k < 3; k++) begin
            ob_one();
            check("R7 idle pulse", 1'b0);
        end

        // R2 R3 R4 R5: sweep force and period
        for (int f = 0; f < 2; f++) begin
            for (int p = 0; p < 8; p++) begin
                force_high = f[0];
                period = PW'(p);
                tick();
                access();
                check((p == 0) ? "R4 zero period" : "R2 load", (f == 1) || (p > 0));
                for (int k = 1; k <= 9; k++) begin
                    ob_one();
                    check((f == 1) ? "R5 force" : "R3 count", (f == 1) || (k < p));
                end
            end
        end
        force_high = 1'b0;
        tick();
        tick();
        check("R5 force released", 1'b0);

        // R6: retrigger mid-window
        period = 3'd4;
        access();
        for (int k = 0; k < 3; k++) ob_one();
        check("R6 before retrigger", 1'b1);
        access();
        for (int k = 1; k <= 4; k++) begin
            ob_one();
            check("R6 reload", k < 4);
        end

        // R9: period change during window
        period = 3'd5;
        access();
        period = 3'd1;
        for (int k = 1; k <= 5; k++) begin
            ob_one();
            check("R9 captured period", k < 5);
        end

        // R10: access end coincident with pulse fall
        period = 3'd3;
        access();
        ob_one();
        ob_one();
        check("R10 one left", 1'b1);
        ob_pulse = 1'b1;
        sel_n = 1'b0;
        tick();
        ob_pulse = 1'b0;
        sel_n = 1'b1;
        tick();
        check("R10 reload wins", 1'b1);
        for (int k = 1; k <= 3; k++) begin
            ob_one();
            check("R10 full window", k < 3);
        end

        // R8: power-down
        period = 3'd7;
        access();
        ob_one();
        pwr_down = 1'b1;
        tick();
        check("R8 clears", 1'b0);
        force_high = 1'b1;
        tick();
        tick();
        check("R8 beats force", 1'b0);
        force_high = 1'b0;
        access();
        check("R8 access ignored", 1'b0);
        pwr_down = 1'b0;
        tick();
        tick();
        check("R8 window gone", 1'b0);
        ob_one();
        check("R8 stays low", 1'b0);
        access();
        check("R8 new access", 1'b1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule